// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block keeps four 16-bit segment bases and turns a segment choice plus a 16-bit offset into a 20-bit physical address. The base is moved up four bit positions and the offset is added to it. The result reaches anywhere in a 1 MB space through 64 KB windows that may overlap. The block also reports which segment is in use as a 2-bit code. It drives an active-low high-lane enable that tells a bus when the upper eight data lines take part in a transfer.

The address, segment code and lane enable are combinational from the current inputs and the stored bases. A data path loads the stack, data and extra bases through a general load port. The code base does not respond to that port. It changes only through a separate control-transfer port. Loads take effect at the rising clock edge, so a read in the next cycle sees the new base.

Top module: `seg_addr_gen`

## Requirements
- R1: While rst is high, the code base becomes 16'hFFFF and the stack, data and extra bases become zero. After reset, selecting code with offset 0 gives address 20'hFFFF0.
- R2: phys_addr equals (selected base << 4) + offset, computed over 20 bits.
- R3: A sum that passes 20'hFFFFF wraps. Base 16'hFFFF with offset 16'h0010 gives 20'h00000.
- R4: The select and seg_code use one encoding: 2'b00 extra, 2'b01 stack, 2'b10 code, 2'b11 data. seg_code always equals the selected segment.
- R5: When ld_en is high and ld_sel names stack, data or extra, that base takes ld_data at the clock edge.
- R6: When ld_en is high and ld_sel names code, nothing is stored. The code base keeps its value.
- R7: When xfer_en is high, the code base takes xfer_base at the clock edge.
- R8: bhe_n is 0 whenever word_xfer is 1.
- R9: For a byte transfer (word_xfer = 0), bhe_n is 0 when phys_addr[0] is 1 and 1 when phys_addr[0] is 0.
- R10: A general load and a control-transfer load in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seg_sel | input | 2 | Segment used for the address |
| offset | input | 16 | Offset within the segment |
| word_xfer | input | 1 | 1 for a 16-bit transfer, 0 for a byte |
| ld_en | input | 1 | General base load strobe |
| ld_sel | input | 2 | Target of the general load |
| ld_data | input | 16 | Value for the general load |
| xfer_en | input | 1 | Control-transfer load of the code base |
| xfer_base | input | 16 | New code base |
| phys_addr | output | 20 | Physical address |
| seg_code | output | 2 | Segment in use |
| bhe_n | output | 1 | High-lane enable, active low |

## Verification
The assertions assume that every input is a known value at each rising edge. They also assume that reset is held for at least one edge before any load is judged. The bench drives every input, including both load strobes, on the falling edge only, and it raises reset for several edges at the start. Random stimulus takes every select, load target, transfer size and strobe combination from the full input range. Directed cases add the wrap point and a code-base load attempted through the general port.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    // Segment encoding, shared by the select inputs and the status code
    typedef enum logic [1:0] {
        SEG_EXTRA = 2'b00,
        SEG_STACK = 2'b01,
        SEG_CODE  = 2'b10,
        SEG_DATA  = 2'b11
    } seg_id_e;

    localparam int unsigned NUM_SEGS = 4;

    typedef struct packed {
        logic    [1:0] code;
        logic          word;
    } xfer_info_t;

    // Active-low upper lane enable: needed for words and odd bytes
    function automatic logic upper_lane_n(input logic word, input logic addr_lsb);
        return !(word || addr_lsb);
    endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_addr_pkg::*;
#(
    parameter int unsigned SEG_W      = 16,
    parameter logic [SEG_W-1:0] CODE_RST = '1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ld_en,
    input  logic [1:0]                     ld_sel,
    input  logic [SEG_W-1:0]               ld_data,
    input  logic                           xfer_en,
    input  logic [SEG_W-1:0]               xfer_base,
    output logic [NUM_SEGS-1:0][SEG_W-1:0] bases
);

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
        localparam bit IS_CODE = (g == int'(SEG_CODE));
        localparam logic [SEG_W-1:0] RST_VAL = IS_CODE ? CODE_RST : '0;

        logic             wr;
        logic [SEG_W-1:0] wr_val;

        if (IS_CODE) begin : g_code
            // only a control transfer may change the code base
            assign wr     = xfer_en;
            assign wr_val = xfer_base;
        end else begin : g_gen
            assign wr     = ld_en && (ld_sel == 2'(g));
            assign wr_val = ld_data;
        end

        always_ff @(posedge clk) begin
            if (rst)      bases[g] <= RST_VAL;
            else if (wr)  bases[g] <= wr_val;
        end
    end

endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc #(
    parameter int unsigned SEG_W = 16,
    parameter int unsigned OFF_W = 16,
    parameter int unsigned SHIFT = 4,
    localparam int unsigned ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] base_sh;
    logic [ADDR_W-1:0] off_ext;

    assign base_sh = {base, {SHIFT{1'b0}}};
    assign off_ext = ADDR_W'(offset);
    // carry out of the top bit is dropped: the space wraps
    assign addr    = base_sh + off_ext;

endmodule

// File: rtl/seg_lane_ctl.sv
module seg_lane_ctl
    import seg_addr_pkg::*;
(
    input  logic [1:0] seg_sel,
    input  logic       word_xfer,
    input  logic       addr_lsb,
    output xfer_info_t info,
    output logic       bhe_n
);

    always_comb begin
        info.code = seg_sel;
        info.word = word_xfer;
        bhe_n     = upper_lane_n(info.word, addr_lsb);
    end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int unsigned SEG_W = 16,
    parameter int unsigned OFF_W = 16,
    parameter int unsigned SHIFT = 4,
    parameter logic [SEG_W-1:0] CODE_RST = '1,
    localparam int unsigned ADDR_W = SEG_W + SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        seg_sel,
    input  logic [OFF_W-1:0]  offset,
    input  logic              word_xfer,
    input  logic              ld_en,
    input  logic [1:0]        ld_sel,
    input  logic [SEG_W-1:0]  ld_data,
    input  logic              xfer_en,
    input  logic [SEG_W-1:0]  xfer_base,
    output logic [ADDR_W-1:0] phys_addr,
    output logic [1:0]        seg_code,
    output logic              bhe_n
);

    logic [NUM_SEGS-1:0][SEG_W-1:0] bases;
    logic [SEG_W-1:0]               sel_base;
    xfer_info_t                     info;

    seg_regfile #(.SEG_W(SEG_W), .CODE_RST(CODE_RST)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (ld_en),
        .ld_sel    (ld_sel),
        .ld_data   (ld_data),
        .xfer_en   (xfer_en),
        .xfer_base (xfer_base),
        .bases     (bases)
    );

    assign sel_base = bases[seg_sel];

    seg_addr_calc #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_calc (
        .base   (sel_base),
        .offset (offset),
        .addr   (phys_addr)
    );

    seg_lane_ctl u_lane (
        .seg_sel   (seg_sel),
        .word_xfer (word_xfer),
        .addr_lsb  (phys_addr[0]),
        .info      (info),
        .bhe_n     (bhe_n)
    );

    assign seg_code = info.code;

endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk
    import seg_addr_pkg::*;
#(
    parameter int unsigned SEG_W  = 16,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned ADDR_W = 20
) (
    input logic                           clk,
    input logic                           rst,
    input logic [1:0]                     seg_sel,
    input logic [OFF_W-1:0]               offset,
    input logic                           word_xfer,
    input logic                           ld_en,
    input logic [1:0]                     ld_sel,
    input logic [SEG_W-1:0]               ld_data,
    input logic                           xfer_en,
    input logic [SEG_W-1:0]               xfer_base,
    input logic [ADDR_W-1:0]              phys_addr,
    input logic [1:0]                     seg_code,
    input logic                           bhe_n,
    input logic [NUM_SEGS-1:0][SEG_W-1:0] bases
);

    // R1: reset values of all bases
    a_r1_reset_vals: assert property (@(posedge clk)
        rst |=> (bases[SEG_CODE] == '1 && bases[SEG_STACK] == '0 &&
                 bases[SEG_DATA] == '0 && bases[SEG_EXTRA] == '0));

    // R2: lowest address bits come straight from the offset
    a_r2_low_nibble: assert property (@(posedge clk) disable iff (rst)
        phys_addr[3:0] == offset[3:0]);

    // R4: status follows the select
    a_r4_seg_code: assert property (@(posedge clk) disable iff (rst)
        seg_code == seg_sel);

    // R5: general load into a non-code base
    a_r5_gen_load: assert property (@(posedge clk) disable iff (rst)
        (ld_en && ld_sel != SEG_CODE) |=> bases[$past(ld_sel)] == $past(ld_data));

    // R6: code base holds without a control transfer
    a_r6_code_locked: assert property (@(posedge clk) disable iff (rst)
        !xfer_en |=> $stable(bases[SEG_CODE]));

    // R7: control transfer loads the code base
    a_r7_xfer_load: assert property (@(posedge clk) disable iff (rst)
        xfer_en |=> bases[SEG_CODE] == $past(xfer_base));

    // R8: word transfers enable the upper lane
    a_r8_word_lane: assert property (@(posedge clk) disable iff (rst)
        word_xfer |-> !bhe_n);

    // R9: even byte transfers keep the upper lane off
    a_r9_even_byte: assert property (@(posedge clk) disable iff (rst)
        (!word_xfer && !phys_addr[0]) |-> bhe_n);

endmodule

bind seg_addr_gen seg_addr_chk #(.SEG_W(SEG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .seg_sel   (seg_sel),
    .offset    (offset),
    .word_xfer (word_xfer),
    .ld_en     (ld_en),
    .ld_sel    (ld_sel),
    .ld_data   (ld_data),
    .xfer_en   (xfer_en),
    .xfer_base (xfer_base),
    .phys_addr (phys_addr),
    .seg_code  (seg_code),
    .bhe_n     (bhe_n),
    .bases     (bases)
);

// File: tb/test_seg_addr_gen.sv
`timescale 1ns/1ps
module test_seg_addr_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  seg_sel = '0;
    logic [15:0] offset = '0;
    logic        word_xfer = 1'b0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_sel = '0;
    logic [15:0] ld_data = '0;
    logic        xfer_en = 1'b0;
    logic [15:0] xfer_base = '0;
    logic [19:0] phys_addr;
    logic [1:0]  seg_code;
    logic        bhe_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] model [4];

    always #10 clk = ~clk;

    seg_addr_gen i_seg_addr_gen (
        .clk(clk), .rst(rst), .seg_sel(seg_sel), .offset(offset),
        .word_xfer(word_xfer), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .xfer_en(xfer_en), .xfer_base(xfer_base),
        .phys_addr(phys_addr), .seg_code(seg_code), .bhe_n(bhe_n)
    );

    function automatic logic [19:0] exp_addr(input logic [15:0] b, input logic [15:0] o);
        logic [20:0] s;
        s = {1'b0, b, 4'b0} + {5'b0, o};
        return s[19:0];
    endfunction

    function automatic logic exp_bhe(input logic w, input logic [19:0] a);
        return !(w || a[0]);
    endfunction

    task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // compare all outputs with the model (called mid-cycle)
    task automatic check_all(input string tag);
        logic [19:0] ea;
        ea = exp_addr(model[seg_sel], offset);
        chk({tag, " R2 address"}, phys_addr, ea);
        chk("R4 seg_code", 20'(seg_code), 20'(seg_sel));
        if (word_xfer) chk("R8 bhe_n word", 20'(bhe_n), 20'(1'b0));
        else           chk("R9 bhe_n byte", 20'(bhe_n), 20'(exp_bhe(1'b0, ea)));
    endtask

    // advance one edge and apply loads to the model
    task automatic tick();
        @(posedge clk);
        if (ld_en && ld_sel != 2'b10) model[ld_sel] = ld_data;
        if (xfer_en) model[2] = xfer_base;
        @(negedge clk);
        ld_en = 1'b0;
        xfer_en = 1'b0;
    endtask

    task automatic probe(input logic [1:0] s, input logic [15:0] o, input logic w);
        seg_sel = s; offset = o; word_xfer = w;
        #1;
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        model[0] = 16'h0; model[1] = 16'h0; model[2] = 16'hFFFF; model[3] = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        probe(2'b10, 16'h0000, 1'b0);
        chk("R1 code reset", phys_addr, 20'hFFFF0);
        probe(2'b11, 16'h0000, 1'b0);
        chk("R1 data reset", phys_addr, 20'h00000);
        probe(2'b01, 16'h0000, 1'b0);
        chk("R1 stack reset", phys_addr, 20'h00000);
        probe(2'b00, 16'h0000, 1'b0);
        chk("R1 extra reset", phys_addr, 20'h00000);

        // R3: wrap at top of space
        probe(2'b10, 16'h0010, 1'b0);
        chk("R3 wrap", phys_addr, 20'h00000);
        probe(2'b10, 16'h0025, 1'b1);
        chk("R3 wrap odd", phys_addr, 20'h00015);

        // R6: general load aimed at code is ignored
        ld_en = 1'b1; ld_sel = 2'b10; ld_data = 16'h1234;
        tick();
        probe(2'b10, 16'h0000, 1'b0);
        chk("R6 code unchanged", phys_addr, 20'hFFFF0);

        // R5: general load of data base
        ld_en = 1'b1; ld_sel = 2'b11; ld_data = 16'h2000;
        tick();
        probe(2'b11, 16'h0003, 1'b0);
        chk("R5 data load", phys_addr, 20'h20003);
        chk("R9 odd byte", 20'(bhe_n), 20'h0);
        probe(2'b11, 16'h0004, 1'b0);
        chk("R9 even byte", 20'(bhe_n), 20'h1);
        probe(2'b11, 16'h0004, 1'b1);
        chk("R8 word even", 20'(bhe_n), 20'h0);

        // R7 and R10: both loads in one cycle
        xfer_en = 1'b1; xfer_base = 16'h0ABC;
        ld_en = 1'b1; ld_sel = 2'b01; ld_data = 16'h3FFF;
        tick();
        probe(2'b10, 16'h0101, 1'b0);
        chk("R7 code load", phys_addr, 20'h0ACC1);
        probe(2'b01, 16'hFFFF, 1'b0);
        chk("R10 stack load", phys_addr, 20'h4FFEF);

        // random mix
        for (int i = 0; i < 400; i++) begin
            ld_en     = 1'($urandom());
            ld_sel    = 2'($urandom());
            ld_data   = 16'($urandom());
            xfer_en   = ($urandom() % 4) == 0;
            xfer_base = 16'($urandom());
            seg_sel   = 2'($urandom());
            offset    = 16'($urandom());
            word_xfer = 1'($urandom());
            #1;
            check_all("rand");
            tick();
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule